// File: doc/BRIEF.md
# Two-Lane RGB888 CSI-2 Packet Builder

This block takes a parallel pixel stream framed by a vertical sync level (`vsync`) and a data-enable level (`de`), and turns it into CSI-2 packets spread over two byte-wide data lanes. Each run of `de` high becomes one long packet with data type 0x24. The packet has a four-byte header (identifier, word count, ECC), the pixel payload and a two-byte CRC footer. When `vsync` falls, the block sends a frame-end short packet. After a programmable number of idle cycles it sends a frame-start short packet. The timing of the frame-start packet does not follow `vsync`.

One full line is held in a line buffer before its header goes out, so the word count is known when the header is sent. The lanes carry the packet bytes in turn: lane 0 carries the even bytes and lane 1 the odd bytes, two bytes per cycle. Start and end of transmission are marked with shared `lane_sot`/`lane_eot` strobes. A narrow input mode widens 6-bit colour inputs to 8-bit channels. The downstream high-speed serialiser takes the bytes and marker strobes directly.

The sequencer states are: `S_IDLE` (waiting), `S_FE_HEAD` and `S_FE_TAIL` (the two cycles of the frame-end packet), `S_GAP` (programmed idle cycles), `S_FS_HEAD` and `S_FS_TAIL` (frame-start packet), `S_LN_HEAD` and `S_LN_TAIL` (long-packet header) and `S_LN_BODY` (payload and CRC).

The transitions are:
- `S_IDLE` goes to `S_LN_HEAD` when a finished line is pending. Otherwise it goes to `S_FE_HEAD` when a `vsync` fall is pending. Lines take priority.
- `S_FE_HEAD` goes to `S_FE_TAIL`.
- `S_FE_TAIL` goes to `S_FS_HEAD` when the gap is zero, and to `S_GAP` otherwise.
- `S_GAP` goes to `S_FS_HEAD` on its last counted cycle.
- `S_FS_HEAD` goes to `S_FS_TAIL`, which returns to `S_IDLE`.
- `S_LN_HEAD` goes to `S_LN_TAIL`, then to `S_LN_BODY`.
- `S_LN_BODY` returns to `S_IDLE` on the cycle that carries the last CRC byte.

Top module: `csi2_rgb_packer`

## Requirements
- R1: While and just after reset, `lane0_valid`, `lane1_valid`, `lane_sot` and `lane_eot` are all 0.
- R2: Frame-end and frame-start packets are each four bytes: data type, number low byte, number high byte, ECC.
  - The falling edge of `vsync` produces a frame-end packet (data type 0x01) and then a frame-start packet (data type 0x00).
  - Each frame-start carries a frame number one higher than the previous frame-start. The first frame-start carries 1.
  - The frame-end carries the number of the latest frame-start, or 0 if there has been none.
- R3: The `lane_sot` cycle of the frame-start packet comes exactly `fe_fs_gap`+1 cycles after the `lane_eot` cycle of the frame-end packet. A value of 0 means back to back.
- R4: Every run of N cycles with `de` high yields one long packet. Its first byte is 0x24, followed by the word count 3·N, low byte first.
- R5: Packet byte i travels on lane (i mod 2), in cycle floor(i/2) of the packet. `lane_sot` marks the first cycle and `lane_eot` the last, so a packet of L bytes spans ceil(L/2) cycles.
- R6: The payload sends each pixel as blue, then green, then red, in pixel order.
- R7: The header ECC is computed over h = byte0 | byte1<<8 | byte2<<16. ECC bit j is the XOR parity of h masked with the j-th of 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00. ECC bits 7:6 are 0.
- R8: The two footer bytes are the CRC low byte, then the high byte. The CRC is taken over the payload only. It starts from 0xFFFF and processes each byte LSB first: feedback = crc[0]^bit, crc >>= 1, and crc ^= 0x8408 when feedback is 1.
- R9: When a packet has an odd byte count, lane 1 is invalid in its final cycle and `lane_eot` is raised in that same cycle.
- R10: With `narrow_mode` high, each colour channel is its input bits [5:0] followed by two zero bits. Input bits [7:6] are ignored.
- R11: A line of `MAX_PIX` pixels is carried intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync level; its fall triggers the frame-end/frame-start pair |
| de | input | 1 | Data enable; high for each pixel of a line |
| narrow_mode | input | 1 | 1 = 6-bit colour inputs in bits [5:0] |
| pix_red | input | 8 | Red input |
| pix_green | input | 8 | Green input |
| pix_blue | input | 8 | Blue input |
| fe_fs_gap | input | 16 | Idle cycles between frame-end and frame-start |
| lane0_byte | output | 8 | Lane 0 byte |
| lane0_valid | output | 1 | Lane 0 byte valid |
| lane1_byte | output | 8 | Lane 1 byte |
| lane1_valid | output | 1 | Lane 1 byte valid |
| lane_sot | output | 1 | Start-of-transmission marker, both lanes |
| lane_eot | output | 1 | End-of-transmission marker, both lanes |

## Verification
The body state tracks a byte index, a pixel phase and a running CRC. If any of these drifts, the error shows within the same line packet: payload bytes are misplaced, the CRC footer differs, or `lane_eot` lands one cycle early or late. A wrong line-buffer pointer shows as pixel data from the wrong line, seen on the next packet. A wrong frame counter or gap counter shows on the next short-packet pair, in the number bytes or in the distance between the frame-end and frame-start markers.

// File: rtl/csi2pk_pkg.sv
package csi2pk_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FE_HEAD,
        S_FE_TAIL,
        S_GAP,
        S_FS_HEAD,
        S_FS_TAIL,
        S_LN_HEAD,
        S_LN_TAIL,
        S_LN_BODY
    } seq_state_t;

    localparam logic [7:0] DT_FRAME_START = 8'h00;
    localparam logic [7:0] DT_FRAME_END   = 8'h01;
    localparam logic [7:0] DT_RGB888      = 8'h24;

    // Hamming parity over a 24-bit packet header, bits 7:6 forced low
    function automatic logic [7:0] hdr_ecc(input logic [23:0] h);
        logic [7:0] e;
        e[0] = ^(h & 24'hF12CB7);
        e[1] = ^(h & 24'hF2555B);
        e[2] = ^(h & 24'h749A6D);
        e[3] = ^(h & 24'hB8E38E);
        e[4] = ^(h & 24'hDF03F0);
        e[5] = ^(h & 24'hEFFC00);
        e[7:6] = 2'b00;
        return e;
    endfunction

    // One byte through the reflected CRC-16 (x^16+x^12+x^5+1)
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    // Colour byte of a packed {R,G,B} pixel: 0 = blue, 1 = green, 2 = red
    function automatic logic [7:0] pick_byte(input logic [23:0] px, input logic [1:0] idx);
        logic [7:0] b;
        unique case (idx)
            2'd0:    b = px[7:0];
            2'd1:    b = px[15:8];
            default: b = px[23:16];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/csi2pk_expand.sv
module csi2pk_expand #(
    parameter int NW = 6
) (
    input  logic        narrow,
    input  logic [7:0]  red,
    input  logic [7:0]  green,
    input  logic [7:0]  blue,
    output logic [23:0] pixel
);
    localparam int CW = 8;
    localparam int PADW = CW - NW;

    logic [3*CW-1:0] raw;
    assign raw = {red, green, blue};

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        assign pixel[ch*CW +: CW] = narrow ? {raw[ch*CW +: NW], {PADW{1'b0}}}
                                           : raw[ch*CW +: CW];
    end
endmodule

// File: rtl/csi2pk_linebuf.sv
module csi2pk_linebuf #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head0,
    output logic [WIDTH-1:0] head1
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, rd_nxt;
    logic [AW:0]      count;

    assign rd_nxt = rd_ptr + 1'b1;
    assign head0  = mem[rd_ptr];
    assign head1  = mem[rd_nxt];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (pop)   rd_ptr <= rd_nxt;
            count <= count + (AW+1)'(wr_en) - (AW+1)'(pop);
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count < (AW+1)'(DEPTH)));
    assert_no_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/csi2pk_seq.sv
module csi2pk_seq
    import csi2pk_pkg::*;
#(
    parameter int MAX_PIX = 64,
    parameter int GAPW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vs,
    input  logic            de,
    input  logic [GAPW-1:0] gap,
    input  logic [23:0]     head0,
    input  logic [23:0]     head1,
    output logic            pop,
    output logic [7:0]      lane0_data,
    output logic            lane0_valid,
    output logic [7:0]      lane1_data,
    output logic            lane1_valid,
    output logic            sot,
    output logic            eot
);
    localparam int WCW = 16;
    localparam int KW  = WCW + 1;
    localparam int PCW = $clog2(MAX_PIX + 1);

    seq_state_t state, state_nx;

    logic            vs_q, de_q;
    logic            frame_pend, line_pend;
    logic [PCW-1:0]  pix_cnt;
    logic [WCW-1:0]  line_wc;
    logic [GAPW-1:0] gap_cnt;
    logic [15:0]     frame_num, fs_num;
    logic [KW-1:0]   k, wc_ext;
    logic [1:0]      phase, phase_nx;
    logic [15:0]     crc, crc_mid, crc_nx;
    logic            pay0, pay1;
    logic [7:0]      body0, body1;
    logic            vs_fall, de_fall;

    assign vs_fall = vs_q && !vs;
    assign de_fall = de_q && !de;
    assign fs_num  = frame_num + 16'd1;
    assign wc_ext  = {1'b0, line_wc};
    assign pay0    = k < wc_ext;
    assign pay1    = (k + KW'(1)) < wc_ext;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (line_pend)       state_nx = S_LN_HEAD;
                else if (frame_pend) state_nx = S_FE_HEAD;
            end
            S_FE_HEAD: state_nx = S_FE_TAIL;
            S_FE_TAIL: state_nx = (gap == '0) ? S_FS_HEAD : S_GAP;
            S_GAP:     if (gap_cnt == GAPW'(1)) state_nx = S_FS_HEAD;
            S_FS_HEAD: state_nx = S_FS_TAIL;
            S_FS_TAIL: state_nx = S_IDLE;
            S_LN_HEAD: state_nx = S_LN_TAIL;
            S_LN_TAIL: state_nx = S_LN_BODY;
            S_LN_BODY: if (k >= wc_ext) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // payload byte pair, CRC and pixel phase for the body
    always_comb begin
        body0    = pick_byte(head0, phase);
        body1    = (phase == 2'd2) ? pick_byte(head1, 2'd0) : pick_byte(head0, phase + 2'd1);
        crc_mid  = pay0 ? crc_step(crc, body0) : crc;
        crc_nx   = pay1 ? crc_step(crc_mid, body1) : crc_mid;
        if (!pay0) body0 = (k == wc_ext) ? crc[7:0] : crc[15:8];
        if (!pay1) body1 = ((k + KW'(1)) == wc_ext) ? crc_mid[7:0] : crc_mid[15:8];
        unique case (phase)
            2'd0:    phase_nx = 2'd2;
            2'd1:    phase_nx = 2'd0;
            default: phase_nx = 2'd1;
        endcase
    end

    // outputs
    always_comb begin
        lane0_data  = 8'h00;
        lane1_data  = 8'h00;
        lane0_valid = 1'b0;
        lane1_valid = 1'b0;
        sot         = 1'b0;
        eot         = 1'b0;
        pop         = 1'b0;
        unique case (state)
            S_FE_HEAD: begin
                lane0_data = DT_FRAME_END; lane1_data = frame_num[7:0];
                lane0_valid = 1'b1; lane1_valid = 1'b1; sot = 1'b1;
            end
            S_FE_TAIL: begin
                lane0_data = frame_num[15:8];
                lane1_data = hdr_ecc({frame_num, DT_FRAME_END});
                lane0_valid = 1'b1; lane1_valid = 1'b1; eot = 1'b1;
            end
            S_FS_HEAD: begin
                lane0_data = DT_FRAME_START; lane1_data = fs_num[7:0];
                lane0_valid = 1'b1; lane1_valid = 1'b1; sot = 1'b1;
            end
            S_FS_TAIL: begin
                lane0_data = fs_num[15:8];
                lane1_data = hdr_ecc({fs_num, DT_FRAME_START});
                lane0_valid = 1'b1; lane1_valid = 1'b1; eot = 1'b1;
            end
            S_LN_HEAD: begin
                lane0_data = DT_RGB888; lane1_data = line_wc[7:0];
                lane0_valid = 1'b1; lane1_valid = 1'b1; sot = 1'b1;
            end
            S_LN_TAIL: begin
                lane0_data = line_wc[15:8];
                lane1_data = hdr_ecc({line_wc, DT_RGB888});
                lane0_valid = 1'b1; lane1_valid = 1'b1;
            end
            S_LN_BODY: begin
                lane0_data  = body0;
                lane1_data  = body1;
                lane0_valid = 1'b1;
                lane1_valid = (k <= wc_ext);
                eot         = (k >= wc_ext);
                pop         = pay0 && (phase != 2'd0);
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0; de_q <= 1'b0;
            frame_pend <= 1'b0; line_pend <= 1'b0;
            pix_cnt <= '0; line_wc <= '0; gap_cnt <= '0; frame_num <= '0;
            k <= '0; phase <= 2'd0; crc <= 16'hFFFF;
        end else begin
            vs_q <= vs;
            de_q <= de;
            if (vs_fall)                 frame_pend <= 1'b1;
            else if (state == S_FE_HEAD) frame_pend <= 1'b0;
            if (de_fall) begin
                line_pend <= 1'b1;
                line_wc   <= WCW'(pix_cnt) * WCW'(3);
                pix_cnt   <= '0;
            end else begin
                if (state == S_LN_HEAD) line_pend <= 1'b0;
                if (de) pix_cnt <= pix_cnt + 1'b1;
            end
            unique case (state)
                S_FE_TAIL: gap_cnt <= gap;
                S_GAP:     gap_cnt <= gap_cnt - 1'b1;
                S_FS_TAIL: frame_num <= fs_num;
                S_LN_TAIL: begin k <= '0; phase <= 2'd0; crc <= 16'hFFFF; end
                S_LN_BODY: begin k <= k + KW'(2); phase <= phase_nx; crc <= crc_nx; end
                default: ;
            endcase
        end
    end

    assert_line_fits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pix_cnt < PCW'(MAX_PIX)));
    assert_sot_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sot |-> (lane0_valid && lane1_valid && !eot));
    assert_sot_then_more_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sot |=> (!sot && lane0_valid));
    assert_idle_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lane1_valid |-> lane0_valid);
    assert_gap_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FE_TAIL && gap != '0) |=> (state == S_GAP && !lane0_valid));
    assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FE_TAIL && gap == '0) |=> sot);
endmodule

// File: rtl/csi2_rgb_packer.sv
module csi2_rgb_packer #(
    parameter int MAX_PIX = 64,
    parameter int NARROW_W = 6,
    parameter int GAPW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vsync,
    input  logic            de,
    input  logic            narrow_mode,
    input  logic [7:0]      pix_red,
    input  logic [7:0]      pix_green,
    input  logic [7:0]      pix_blue,
    input  logic [GAPW-1:0] fe_fs_gap,
    output logic [7:0]      lane0_byte,
    output logic            lane0_valid,
    output logic [7:0]      lane1_byte,
    output logic            lane1_valid,
    output logic            lane_sot,
    output logic            lane_eot
);
    localparam int BUF_DEPTH = 1 << $clog2(2 * MAX_PIX);

    logic [23:0] wide_px, head0, head1;
    logic        pop;

    csi2pk_expand #(.NW(NARROW_W)) u_expand (
        .narrow (narrow_mode),
        .red    (pix_red),
        .green  (pix_green),
        .blue   (pix_blue),
        .pixel  (wide_px)
    );

    csi2pk_linebuf #(.WIDTH(24), .DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (de),
        .wr_data (wide_px),
        .pop     (pop),
        .head0   (head0),
        .head1   (head1)
    );

    csi2pk_seq #(.MAX_PIX(MAX_PIX), .GAPW(GAPW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .vs          (vsync),
        .de          (de),
        .gap         (fe_fs_gap),
        .head0       (head0),
        .head1       (head1),
        .pop         (pop),
        .lane0_data  (lane0_byte),
        .lane0_valid (lane0_valid),
        .lane1_data  (lane1_byte),
        .lane1_valid (lane1_valid),
        .sot         (lane_sot),
        .eot         (lane_eot)
    );

    assert_eot_on_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_eot |-> lane0_valid);
    assert_markers_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_eot |=> !lane1_valid || lane_sot);
endmodule

// File: tb/csi2_rgb_packer_test.sv
`timescale 1ns/1ps
module csi2_rgb_packer_test;
    localparam int MP  = 16;
    localparam int NPK = 64;
    localparam int NB  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, de = 1'b0, narrow_mode = 1'b0;
    logic [7:0]  pix_red = '0, pix_green = '0, pix_blue = '0;
    logic [15:0] fe_fs_gap = '0;
    logic [7:0]  lane0_byte, lane1_byte;
    logic        lane0_valid, lane1_valid, lane_sot, lane_eot;

    always #10 clk = ~clk;

    csi2_rgb_packer #(.MAX_PIX(MP)) uut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .de(de), .narrow_mode(narrow_mode),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .fe_fs_gap(fe_fs_gap),
        .lane0_byte(lane0_byte), .lane0_valid(lane0_valid),
        .lane1_byte(lane1_byte), .lane1_valid(lane1_valid),
        .lane_sot(lane_sot), .lane_eot(lane_eot)
    );

    int errs = 0, nchk = 0, cyc = 0;

    // expected packets
    logic [7:0] exp_b [NPK][NB];
    int exp_len [NPK];
    int exp_gap [NPK];   // -1 unless a frame-start packet
    int exp_kind [NPK];  // 0 short, 1 long, 2 long narrow
    int nexp = 0;
    int fnum = 0;

    // captured packets
    logic [7:0] cap_b [NPK][NB];
    int cap_len [NPK], cap_sot [NPK], cap_eot [NPK];
    logic cap_l1 [NPK];
    int ncap = 0, cur_len = 0, cur_sot = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            errs = errs + 1; nchk = nchk + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (lane_sot) begin cur_len = 0; cur_sot = cyc; end
            if (lane0_valid) begin
                if (ncap < NPK && cur_len < NB) cap_b[ncap][cur_len] = lane0_byte;
                cur_len++;
            end
            if (lane1_valid) begin
                if (ncap < NPK && cur_len < NB) cap_b[ncap][cur_len] = lane1_byte;
                cur_len++;
            end
            if (lane_eot && ncap < NPK) begin
                cap_len[ncap] = cur_len; cap_sot[ncap] = cur_sot;
                cap_eot[ncap] = cyc; cap_l1[ncap] = lane1_valid;
                ncap++;
            end
        end
    end

    function automatic logic [7:0] ref_ecc(input logic [23:0] h);
        logic [23:0] m [6];
        logic [7:0] e;
        m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
        m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
        e = 8'h00;
        for (int j = 0; j < 6; j++) begin
            for (int b = 0; b < 24; b++) e[j] = e[j] ^ (h[b] & m[j][b]);
        end
        return e;
    endfunction

    function automatic logic [15:0] ref_crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic add_short(input logic [7:0] dt, input int num, input int g);
        logic [23:0] h;
        h = {num[15:0], dt};
        exp_b[nexp][0] = dt; exp_b[nexp][1] = num[7:0];
        exp_b[nexp][2] = num[15:8]; exp_b[nexp][3] = ref_ecc(h);
        exp_len[nexp] = 4; exp_gap[nexp] = g; exp_kind[nexp] = 0;
        nexp++;
    endtask

    task automatic send_frame_sync(input int g);
        fe_fs_gap = g[15:0];
        vsync = 1'b1;
        repeat (3) tick();
        vsync = 1'b0;
        add_short(8'h01, fnum, -1);
        fnum = (fnum + 1) % 65536;
        add_short(8'h00, fnum, g);
        repeat (g + 12) tick();
    endtask

    task automatic send_line(input int n, input logic nar, input int lid);
        logic [7:0] r, gc, b;
        logic [15:0] crc;
        int wc, p;
        wc = 3 * n;
        exp_b[nexp][0] = 8'h24; exp_b[nexp][1] = wc[7:0]; exp_b[nexp][2] = wc[15:8];
        exp_b[nexp][3] = ref_ecc({wc[15:0], 8'h24});
        p = 4; crc = 16'hFFFF;
        narrow_mode = nar;
        for (int i = 0; i < n; i++) begin
            r  = 8'((i * 37 + lid * 11 + 5) | 8'hC0 * nar);
            gc = 8'(i * 53 + lid * 7 + 1);
            b  = 8'(i * 19 + lid * 3 + 9);
            pix_red = r; pix_green = gc; pix_blue = b;
            de = 1'b1;
            if (nar) begin r = {r[5:0], 2'b00}; gc = {gc[5:0], 2'b00}; b = {b[5:0], 2'b00}; end
            exp_b[nexp][p] = b;   crc = ref_crc_byte(crc, b);  p++;
            exp_b[nexp][p] = gc;  crc = ref_crc_byte(crc, gc); p++;
            exp_b[nexp][p] = r;   crc = ref_crc_byte(crc, r);  p++;
            tick();
        end
        de = 1'b0;
        exp_b[nexp][p] = crc[7:0]; exp_b[nexp][p+1] = crc[15:8];
        exp_len[nexp] = p + 2; exp_gap[nexp] = -1; exp_kind[nexp] = nar ? 2 : 1;
        nexp++;
        repeat ((3 * n) / 2 + 12) tick();
    endtask

    function automatic string byte_tag(input int kind, input int i, input int len);
        if (kind == 0) return (i == 3) ? "R7 frame ECC" : "R2 frame number";
        if (i < 3) return "R4 header";
        if (i == 3) return "R7 header ECC";
        if (i >= len - 2) return "R8 CRC footer";
        return (kind == 2) ? "R10 narrow payload" : "R6 payload order";
    endfunction

    initial begin
        repeat (3) tick();
        check(!lane0_valid && !lane1_valid && !lane_sot && !lane_eot,
              "R1 outputs during reset", {lane0_valid, lane1_valid, lane_sot, lane_eot}, 0);
        rst_n = 1'b1;
        tick(); tick();
        check(!lane0_valid && !lane1_valid && !lane_sot && !lane_eot,
              "R1 outputs after reset", {lane0_valid, lane1_valid, lane_sot, lane_eot}, 0);

        send_frame_sync(0);
        for (int n = 1; n <= 8; n++) send_line(n, 1'b0, n);
        send_frame_sync(3);
        for (int n = 1; n <= 8; n++) send_line(n, 1'b1, n + 20);
        send_frame_sync(1);
        send_line(MP, 1'b0, 40);   // R11 full-length line
        send_line(MP, 1'b1, 41);
        send_frame_sync(5);
        repeat (20) tick();

        check(ncap == nexp, "R4 R2 packet count", ncap, nexp);
        for (int pk = 0; pk < nexp && pk < ncap; pk++) begin
            int bad;
            bad = -1;
            check(cap_len[pk] == exp_len[pk], "R4 packet length", cap_len[pk], exp_len[pk]);
            for (int i = 0; i < exp_len[pk] && i < NB; i++)
                if (bad < 0 && cap_b[pk][i] !== exp_b[pk][i]) bad = i;
            if (bad >= 0)
                check(1'b0, byte_tag(exp_kind[pk], bad, exp_len[pk]),
                      int'(cap_b[pk][bad]), int'(exp_b[pk][bad]));
            else
                check(1'b1, "R6", 0, 0);
            check(cap_eot[pk] - cap_sot[pk] == (exp_len[pk] + 1) / 2 - 1,
                  "R5 packet span in cycles", cap_eot[pk] - cap_sot[pk], (exp_len[pk] + 1) / 2 - 1);
            check(cap_l1[pk] == ((exp_len[pk] % 2) == 0),
                  "R9 lane1 valid at end", int'(cap_l1[pk]), int'((exp_len[pk] % 2) == 0));
            if (exp_gap[pk] >= 0 && pk > 0)
                check(cap_sot[pk] - cap_eot[pk-1] == exp_gap[pk] + 1,
                      "R3 frame-end to frame-start distance", cap_sot[pk] - cap_eot[pk-1], exp_gap[pk] + 1);
        end
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule